// File: doc/BRIEF.md
# Interrupt Shadow Inhibit Tracker

Some instructions open a one-instruction shadow. While the shadow is open, the processor must not take external interrupts. After a stack-segment load it must also hold off debug and single-step traps. This block keeps that shadow. It counts retired instructions. When an arming event arrives, it records which classes of event are blocked and a deadline equal to the retire count plus one. At every instruction boundary it answers two combinational questions: are interrupts blocked, and are debug traps blocked.

The same state is shared with a virtualization layer. On a VM entry, a two-bit interruptibility code is loaded into the tracker. On a VM exit, the code for the current state is presented on an output. A VM launch request made while the full stack-load shadow is open produces a failure pulse in the same cycle. The core's boundary logic evaluates the debug-trap answer first and the interrupt answer second.

Top module: `irq_shadow_tracker`

## Requirements
- R1: After reset the retire count is 0, both block outputs are 0, the exit code is 2'b00, and no launch failure is signalled.
- R2: The retire count increases by exactly one in each cycle where `retire_i` is high, and holds otherwise.
- R3: A stack-segment load event arms both cause bits. Interrupts and debug traps then both read blocked, and the exit code is 2'b10 (blocked by stack load).
- R4: An STI event with `if_prev_i` low arms only the interrupt bit. Interrupts read blocked, debug traps read unblocked, and the exit code is 2'b01 (blocked by STI).
- R5: An STI event with `if_prev_i` high arms nothing and leaves any window that is already open, together with its cause bits, unchanged.
- R6: Arming replaces the whole cause mask rather than merging into it. An STI arm inside a stack-load window drops debug blocking.
- R7: Arming stores a deadline of the pre-increment retire count plus one, even when a retire occurs in the same cycle. A query is true only while the count is at or below the deadline and every requested cause bit is set.
- R8: On VM entry, code bit 0 (blocked by STI) arms the interrupt-only mask and takes precedence. Otherwise bit 1 (blocked by stack load) arms both bits. Code 2'b00 clears the mask.
- R9: `launch_fail_o` is high in the same cycle as `vm_launch_i` exactly when both cause bits are active inside the window.
- R10: When several arming sources fire in one cycle, VM entry wins over a stack-segment load, and a stack-segment load wins over STI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction, string iteration or faulting instruction completed |
| sti_evt_i | input | 1 | STI executed this cycle |
| if_prev_i | input | 1 | Interrupt-enable flag value before the STI |
| ss_load_evt_i | input | 1 | Stack-segment load executed this cycle |
| vm_entry_i | input | 1 | VM entry loads the interruptibility code |
| vm_entry_code_i | input | 2 | Code to load: bit 0 blocked by STI, bit 1 blocked by stack load |
| vm_launch_i | input | 1 | VM launch request |
| irq_block_o | output | 1 | External interrupts blocked at this boundary |
| dbg_block_o | output | 1 | Debug and single-step traps blocked at this boundary |
| vm_exit_code_o | output | 2 | Interruptibility code to save on VM exit |
| launch_fail_o | output | 1 | Launch refused because stack-load blocking is active |
| retire_cnt_o | output | 64 | Retired-instruction count |

## Verification
The hardest situation to reach is the edge of the deadline window. Depending on whether the arm and a retire share a cycle, the window lasts one or two further retires, and a second arm can land inside a window that is still open. The stimulus drives single-cycle event patterns. It arms with and without a simultaneous retire, then steps retires one at a time and checks the block outputs after each step. It also re-arms, or sends an STI that must not arm, while a stack-load window is still open, which exposes whether the cause mask is replaced and whether the deadline moves.

// File: rtl/ishd_pkg.sv
package ishd_pkg;
   typedef logic [1:0] cause_t;
   localparam cause_t CAUSE_NONE = 2'b00;
   localparam cause_t CAUSE_IRQ  = 2'b01;
   localparam cause_t CAUSE_DBG  = 2'b10;
   localparam cause_t CAUSE_BOTH = 2'b11;

   typedef logic [1:0] vmcode_t;
   localparam vmcode_t VMCODE_NONE = 2'b00;
   localparam vmcode_t VMCODE_STI  = 2'b01;
   localparam vmcode_t VMCODE_SS   = 2'b10;

   localparam int NUM_QUERIES = 3;

   function automatic cause_t query_mask(input int idx);
      case (idx)
         0:       return CAUSE_IRQ;
         1:       return CAUSE_DBG;
         default: return CAUSE_BOTH;
      endcase
   endfunction
endpackage

// File: rtl/ishd_retire_ctr.sv
module ishd_retire_ctr #(
   parameter int CNT_W    = 64,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   initial begin
      if (CNT_W < 2) $error("ishd_retire_ctr: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   generate
      if (SATURATE) begin : g_sat
         always_comb step = retire_i && (cnt_q != '1);
      end else begin : g_wrap
         always_comb step = retire_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + ONE;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/ishd_arm_reg.sv
module ishd_arm_reg
   import ishd_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             sti_evt_i,
   input  logic             if_prev_i,
   input  logic             ss_load_evt_i,
   input  logic             vm_entry_i,
   input  vmcode_t          vm_entry_code_i,
   output cause_t           mask_o,
   output logic [CNT_W-1:0] deadline_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cause_t           mask_q, mask_d;
   logic [CNT_W-1:0] dl_q, dl_d;

   always_comb begin
      mask_d = mask_q;
      dl_d   = dl_q;
      if (vm_entry_i) begin
         if (vm_entry_code_i[0]) begin
            mask_d = CAUSE_IRQ;
            dl_d   = cnt_i + ONE;
         end else if (vm_entry_code_i[1]) begin
            mask_d = CAUSE_BOTH;
            dl_d   = cnt_i + ONE;
         end else begin
            mask_d = CAUSE_NONE;
         end
      end else if (ss_load_evt_i) begin
         mask_d = CAUSE_BOTH;
         dl_d   = cnt_i + ONE;
      end else if (sti_evt_i && !if_prev_i) begin
         mask_d = CAUSE_IRQ;
         dl_d   = cnt_i + ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= CAUSE_NONE;
         dl_q   <= '0;
      end else begin
         mask_q <= mask_d;
         dl_q   <= dl_d;
      end
   end

   assign mask_o     = mask_q;
   assign deadline_o = dl_q;
endmodule

// File: rtl/ishd_query.sv
module ishd_query
   import ishd_pkg::*;
#(
   parameter int     CNT_W = 64,
   parameter cause_t REQ   = CAUSE_IRQ
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] deadline_i,
   input  cause_t           mask_i,
   output logic             hit_o
);
   initial begin
      if (REQ == CAUSE_NONE) $error("ishd_query: REQ must name at least one cause");
   end

   logic in_window;
   always_comb begin
      in_window = (cnt_i <= deadline_i);
      hit_o     = in_window && ((mask_i & REQ) == REQ);
   end
endmodule

// File: rtl/irq_shadow_tracker.sv
module irq_shadow_tracker
   import ishd_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             sti_evt_i,
   input  logic             if_prev_i,
   input  logic             ss_load_evt_i,
   input  logic             vm_entry_i,
   input  logic [1:0]       vm_entry_code_i,
   input  logic             vm_launch_i,
   output logic             irq_block_o,
   output logic             dbg_block_o,
   output logic [1:0]       vm_exit_code_o,
   output logic             launch_fail_o,
   output logic [CNT_W-1:0] retire_cnt_o
);
   logic [CNT_W-1:0]       cnt;
   logic [CNT_W-1:0]       deadline;
   cause_t                 mask;
   logic [NUM_QUERIES-1:0] hits;

   ishd_retire_ctr #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .retire_i (retire_i),
      .cnt_o    (cnt)
   );

   ishd_arm_reg #(.CNT_W(CNT_W)) u_arm (
      .clk             (clk),
      .rst_n           (rst_n),
      .cnt_i           (cnt),
      .sti_evt_i       (sti_evt_i),
      .if_prev_i       (if_prev_i),
      .ss_load_evt_i   (ss_load_evt_i),
      .vm_entry_i      (vm_entry_i),
      .vm_entry_code_i (vm_entry_code_i),
      .mask_o          (mask),
      .deadline_o      (deadline)
   );

   generate
      for (genvar q = 0; q < NUM_QUERIES; q++) begin : g_query
         ishd_query #(.CNT_W(CNT_W), .REQ(query_mask(q))) u_q (
            .cnt_i      (cnt),
            .deadline_i (deadline),
            .mask_i     (mask),
            .hit_o      (hits[q])
         );
      end
   endgenerate

   always_comb begin
      irq_block_o   = hits[0];
      dbg_block_o   = hits[1];
      launch_fail_o = vm_launch_i && hits[2];
      if (!hits[0])     vm_exit_code_o = VMCODE_NONE;
      else if (hits[1]) vm_exit_code_o = VMCODE_SS;
      else              vm_exit_code_o = VMCODE_STI;
   end

   assign retire_cnt_o = cnt;
endmodule

// File: rtl/irq_shadow_chk.sv
module irq_shadow_chk #(
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             retire_i,
   input logic             sti_evt_i,
   input logic             if_prev_i,
   input logic             ss_load_evt_i,
   input logic             vm_entry_i,
   input logic             vm_launch_i,
   input logic             irq_block_o,
   input logic             dbg_block_o,
   input logic [1:0]       vm_exit_code_o,
   input logic             launch_fail_o,
   input logic [CNT_W-1:0] retire_cnt_o
);
   AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && retire_cnt_o != '1) |=> retire_cnt_o == $past(retire_cnt_o) + CNT_W'(1)); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_i |=> $stable(retire_cnt_o)); // R2

   AST_SS_ARMS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_load_evt_i && !vm_entry_i) |=> (irq_block_o && dbg_block_o)); // R3

   AST_STI_ARMS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (sti_evt_i && !if_prev_i && !ss_load_evt_i && !vm_entry_i)
      |=> (irq_block_o && !dbg_block_o && vm_exit_code_o == 2'b01)); // R4

   AST_STI_SET_NOARM: assert property (@(posedge clk) disable iff (!rst_n)
      (sti_evt_i && if_prev_i && !ss_load_evt_i && !vm_entry_i && !irq_block_o)
      |=> !irq_block_o); // R5

   AST_DBG_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_block_o |-> irq_block_o); // R3

   AST_LAUNCH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      launch_fail_o |-> (vm_launch_i && vm_exit_code_o == 2'b10)); // R9
endmodule

bind irq_shadow_tracker irq_shadow_chk #(.CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .retire_i       (retire_i),
   .sti_evt_i      (sti_evt_i),
   .if_prev_i      (if_prev_i),
   .ss_load_evt_i  (ss_load_evt_i),
   .vm_entry_i     (vm_entry_i),
   .vm_launch_i    (vm_launch_i),
   .irq_block_o    (irq_block_o),
   .dbg_block_o    (dbg_block_o),
   .vm_exit_code_o (vm_exit_code_o),
   .launch_fail_o  (launch_fail_o),
   .retire_cnt_o   (retire_cnt_o)
);

// File: tb/irq_shadow_tracker_tb.sv
module irq_shadow_tracker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire_i = 1'b0, sti_evt_i = 1'b0, if_prev_i = 1'b0;
   logic        ss_load_evt_i = 1'b0, vm_entry_i = 1'b0, vm_launch_i = 1'b0;
   logic [1:0]  vm_entry_code_i = 2'b00;
   logic        irq_block_o, dbg_block_o, launch_fail_o;
   logic [1:0]  vm_exit_code_o;
   logic [63:0] retire_cnt_o;

   int          n_chk = 0, n_fail = 0;
   logic [63:0] exp_cnt = 64'd0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   irq_shadow_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .sti_evt_i(sti_evt_i),
      .if_prev_i(if_prev_i), .ss_load_evt_i(ss_load_evt_i), .vm_entry_i(vm_entry_i),
      .vm_entry_code_i(vm_entry_code_i), .vm_launch_i(vm_launch_i),
      .irq_block_o(irq_block_o), .dbg_block_o(dbg_block_o),
      .vm_exit_code_o(vm_exit_code_o), .launch_fail_o(launch_fail_o),
      .retire_cnt_o(retire_cnt_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic ret, input logic sti, input logic ifl, input logic ss,
                      input logic vme, input logic [1:0] code);
      @(negedge clk);
      retire_i = ret; sti_evt_i = sti; if_prev_i = ifl; ss_load_evt_i = ss;
      vm_entry_i = vme; vm_entry_code_i = code;
      @(negedge clk);
      retire_i = 0; sti_evt_i = 0; if_prev_i = 0; ss_load_evt_i = 0;
      vm_entry_i = 0; vm_entry_code_i = 2'b00;
      if (ret) exp_cnt++;
      #1;
   endtask

   task automatic state(input string req, input logic irq, input logic dbg, input logic [1:0] code);
      chk({req, " irq"}, {63'd0, irq_block_o}, {63'd0, irq});
      chk({req, " dbg"}, {63'd0, dbg_block_o}, {63'd0, dbg});
      chk({req, " exit"}, {62'd0, vm_exit_code_o}, {62'd0, code});
   endtask

   task automatic launch(input string req, input logic exp);
      vm_launch_i = 1'b1;
      #1;
      chk(req, {63'd0, launch_fail_o}, {63'd0, exp});
      vm_launch_i = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      chk("R1 count", retire_cnt_o, 64'd0);
      state("R1", 0, 0, 2'b00);
      launch("R1 launch", 0);
   endtask

   task automatic t_count;
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 2'b00);
      chk("R2 after five", retire_cnt_o, exp_cnt);
      cyc(0, 0, 0, 0, 0, 2'b00);
      chk("R2 hold", retire_cnt_o, exp_cnt);
   endtask

   task automatic t_ss_window;
      cyc(1, 0, 0, 1, 0, 2'b00);          // arm with same-cycle retire
      state("R3 ss arm", 1, 1, 2'b10);
      launch("R9 launch blocked", 1);
      cyc(1, 0, 0, 0, 0, 2'b00);
      state("R7 closed after one retire", 0, 0, 2'b00);
      launch("R9 launch ok", 0);
      cyc(0, 0, 0, 1, 0, 2'b00);          // arm without retire
      cyc(1, 0, 0, 0, 0, 2'b00);
      state("R7 still open at deadline", 1, 1, 2'b10);
      cyc(1, 0, 0, 0, 0, 2'b00);
      state("R7 closed past deadline", 0, 0, 2'b00);
   endtask

   task automatic t_sti;
      cyc(1, 1, 0, 0, 0, 2'b00);
      state("R4 sti arm", 1, 0, 2'b01);
      launch("R9 sti no fail", 0);
      cyc(1, 0, 0, 0, 0, 2'b00);
      state("R4 sti closed", 0, 0, 2'b00);
      cyc(1, 1, 1, 0, 0, 2'b00);
      state("R5 sti flag set", 0, 0, 2'b00);
      cyc(0, 0, 0, 1, 0, 2'b00);
      cyc(0, 1, 1, 0, 0, 2'b00);
      state("R5 window kept", 1, 1, 2'b10);
      cyc(1, 0, 0, 0, 0, 2'b00);
      cyc(1, 0, 0, 0, 0, 2'b00);
      state("R5 deadline not moved", 0, 0, 2'b00);
   endtask

   task automatic t_replace;
      cyc(0, 0, 0, 1, 0, 2'b00);
      cyc(0, 1, 0, 0, 0, 2'b00);
      state("R6 replaced by sti", 1, 0, 2'b01);
      cyc(1, 0, 0, 0, 0, 2'b00);
      cyc(1, 0, 0, 0, 0, 2'b00);
      state("R6 closed", 0, 0, 2'b00);
   endtask

   task automatic t_vm;
      cyc(0, 0, 0, 0, 1, 2'b01);
      state("R8 load sti", 1, 0, 2'b01);
      cyc(0, 0, 0, 0, 1, 2'b10);
      state("R8 load ss", 1, 1, 2'b10);
      launch("R9 after vm load", 1);
      cyc(0, 0, 0, 0, 1, 2'b00);
      state("R8 load none", 0, 0, 2'b00);
      cyc(0, 0, 0, 0, 1, 2'b11);
      state("R8 both bits sti wins", 1, 0, 2'b01);
      cyc(1, 0, 0, 0, 0, 2'b00);
      cyc(1, 0, 0, 0, 0, 2'b00);
      state("R8 closed", 0, 0, 2'b00);
   endtask

   task automatic t_priority;
      cyc(1, 1, 0, 1, 0, 2'b00);
      state("R10 ss over sti", 1, 1, 2'b10);
      cyc(0, 0, 0, 1, 1, 2'b00);
      state("R10 vm entry over ss", 0, 0, 2'b00);
      cyc(0, 1, 0, 0, 1, 2'b10);
      state("R10 vm entry over sti", 1, 1, 2'b10);
      cyc(1, 0, 0, 0, 0, 2'b00);
      cyc(1, 0, 0, 0, 0, 2'b00);
      chk("R2 final count", retire_cnt_o, exp_cnt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset;
      t_count;
      t_ss_window;
      t_sti;
      t_replace;
      t_vm;
      t_priority;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule